// File: doc/BRIEF.md
# Synchronous Serial Byte Transceiver

This block moves one byte at a time over a three-wire synchronous link (clock, data in, data out) in full duplex. Software writes the outgoing byte into the data register, chooses the mode in the control register and sets the enable and go bits in the same write. The block then shifts eight bits out on `so` while it captures eight bits from `si`. It can drive the serial clock itself as master or follow a clock that another device drives as slave. Clock idle level, sampling edge and bit order can each be set. That gives four clock formats and eight modes in all.

The received bits collect in an internal buffer. The data register keeps the transmit byte until the eighth bit is done. At that point the captured byte replaces it, an interrupt flag is set, and the block clears its own enable and go bits. The next byte needs a new control write. As master, the clock comes from the system clock. It is divided by 1, 8, 16 or 32 and then passed through an 8-bit up-counter that reloads itself from a reload register. The serial clock toggles on every counter overflow.

The register port is a plain write strobe with an address and write data. The register contents are always visible on dedicated read outputs. The serial pins have no valid/ready handshake: the serial clock paces the data, and nothing is held back.

Top module: `sio_xcvr`

## Requirements
- R1: After reset, `data_q`, `ctrl_q`, `irq`, `od_en`, `sck_o`, `sck_oe` and `so` are all 0.
- R2: Register addresses: 0 is control, 1 is data, 2 is clock reload, 3 is flags. The control bits are: [7] enable, [6] go/busy, [5] master, [4] LSB-first, [3] clock idle level, [2] second-edge sampling, [1:0] rate select. `ctrl_q` reads back the control register, and bit 6 shows whether a transfer is active.
- R3: A transfer begins only on a control write with both bit 7 and bit 6 set. A write with bit 6 set but bit 7 clear starts nothing. A write with bit 7 set and bit 6 clear only stores enable.
- R4: A transfer moves exactly eight bits. During the transfer `data_q` keeps the transmit byte. At completion `data_q` takes the eight captured bits.
- R5: With bit 4 = 0 the most significant bit goes first on `so`, and the first received bit lands in bit 7. With bit 4 = 1 the least significant bit goes first, and the first received bit lands in bit 0.
- R6: When idle, `sck_o` equals control bit 3. In master mode `sck_o` returns to that level after the transfer. `sck_oe` equals the master bit.
- R7: With bit 2 = 0, the first bit is on `so` as soon as the transfer starts, `si` is sampled on the leading clock edge and `so` changes on the trailing edge. With bit 2 = 1, `so` changes on each leading edge after the first, and `si` is sampled on the trailing edge.
- R8: In master mode, each half period of `sck_o` lasts (256 − reload) × D system clocks. D is 1, 8, 16 or 32 for rate select 0, 1, 2 or 3.
- R9: `irq` goes to 1 when a transfer completes. It stays at 1 until a flags write with bit 0 = 1. A flags write with bit 0 = 0 leaves it unchanged.
- R10: After completion, control bits 7 and 6 read 0.
- R11: While a transfer is active, writes to the control, data and reload registers are ignored.
- R12: In slave mode, the block follows `sck_i` through a two-stage synchronizer with edge detection, and `sck_oe` is 0.
- R13: Flags bit 1 sets `od_en`, which marks the pins for open-drain use. It can be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| data_q | output | 8 | Data register contents |
| ctrl_q | output | 8 | Control register readback, with the busy bit |
| irq | output | 1 | End-of-transfer interrupt flag |
| od_en | output | 1 | Open-drain enable flag |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |

## Verification
A bit counter in the wrong state shows up within one byte. The busy bit would clear too early or too late, and both `data_q` and the `sck_o` edge count would be off by the time the bench expects completion. A faulty shift register or a wrong order select shows as a byte that is reversed or shifted, either in the bits seen on `so` or in the captured `data_q`. Both are checked in all eight modes. A wrong prescaler or reload path shows as a wrong half period at the very next `sck_o` toggle. A faulty busy gate lets a register write through, and that shows on `data_q` or `ctrl_q` on the next cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_DATA   = 2'd1,
    A_RELOAD = 2'd2,
    A_FLAGS  = 2'd3
  } sio_addr_e;

  localparam int CTRL_EN   = 7;
  localparam int CTRL_GO   = 6;
  localparam int CTRL_MST  = 5;
  localparam int CTRL_LSB  = 4;
  localparam int CTRL_CPOL = 3;
  localparam int CTRL_CPHA = 2;
  localparam int FLG_IRQ   = 0;
  localparam int FLG_OD    = 1;

  typedef struct packed {
    logic       en;
    logic       master;
    logic       lsb_first;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } sio_cfg_t;

  function automatic int unsigned prescale_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen import sio_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       rate,
  input  logic [CNT_W-1:0] reload,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = run && (pcnt == PRE_W'(prescale_div(rate) - 1));
  assign ovf  = tick && (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      cnt  <= '0;
    end else if (!run) begin
      pcnt <= '0;
      cnt  <= reload;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) cnt <= (cnt == CNT_TOP) ? reload : cnt + 1'b1;
    end
  end

  assert_prescale_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && tick |-> $past(pcnt) == pcnt - 1'b1 || $past(tick));

endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], sck_i};
  end

  assign rise =  pipe[STAGES-1] && !pipe[STAGES];
  assign fall = !pipe[STAGES-1] &&  pipe[STAGES];

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] tx_byte,
  input  logic          lsb_first,
  input  logic          cpha,
  input  logic          lead,
  input  logic          trail,
  input  logic          si,
  output logic          so,
  output logic [DW-1:0] rx_byte,
  output logic          done
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] tx_sr, rx_sr, rx_shift;
  logic [CW-1:0] bcnt;
  logic          first, sample_ev, shift_ev;

  assign sample_ev = cpha ? trail : lead;
  assign shift_ev  = cpha ? (lead && !first) : trail;
  assign rx_shift  = lsb_first ? {si, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], si};
  assign rx_byte   = sample_ev ? rx_shift : rx_sr;
  assign done      = trail && (bcnt == LAST);
  assign so        = lsb_first ? tx_sr[0] : tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
      bcnt  <= '0;
      first <= 1'b0;
    end else if (load) begin
      tx_sr <= tx_byte;
      rx_sr <= '0;
      bcnt  <= '0;
      first <= 1'b1;
    end else begin
      if (sample_ev) rx_sr <= rx_shift;
      if (shift_ev)  tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      if (lead)      first <= 1'b0;
      if (trail)     bcnt  <= bcnt + 1'b1;
    end
  end

  assert_edges_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail));

  assert_lead_before_trail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trail |-> !first);

  assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bcnt == '0);

endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr import sio_pkg::*; #(
  parameter int DW          = 8,
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] data_q,
  output logic [7:0]    ctrl_q,
  output logic          irq,
  output logic          od_en,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          si,
  output logic          so
);
  sio_cfg_t         cfg;
  logic             busy, irq_r, od_r, sck_r;
  logic [DW-1:0]    data_r, rx_byte;
  logic [CNT_W-1:0] reload_r;
  logic             wr_ok, go, m_ovf, s_rise, s_fall, lead, trail, done;

  assign wr_ok = reg_we && !busy;
  assign go    = wr_ok && (reg_addr == A_CTRL) && reg_wdata[CTRL_EN] && reg_wdata[CTRL_GO];

  sio_rate_gen #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy && cfg.master),
    .rate(cfg.rate), .reload(reload_r), .ovf(m_ovf)
  );

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .rise(s_rise), .fall(s_fall)
  );

  always_comb begin
    lead  = 1'b0;
    trail = 1'b0;
    if (busy) begin
      if (cfg.master) begin
        lead  = m_ovf && (sck_r == cfg.cpol);
        trail = m_ovf && (sck_r != cfg.cpol);
      end else begin
        lead  = cfg.cpol ? s_fall : s_rise;
        trail = cfg.cpol ? s_rise : s_fall;
      end
    end
  end

  sio_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(go), .tx_byte(data_r),
    .lsb_first(cfg.lsb_first), .cpha(cfg.cpha), .lead(lead), .trail(trail),
    .si(si), .so(so), .rx_byte(rx_byte), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      busy     <= 1'b0;
      data_r   <= '0;
      reload_r <= '0;
      irq_r    <= 1'b0;
      od_r     <= 1'b0;
      sck_r    <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == A_CTRL) begin
        cfg <= '{en:        reg_wdata[CTRL_EN],
                 master:    reg_wdata[CTRL_MST],
                 lsb_first: reg_wdata[CTRL_LSB],
                 cpol:      reg_wdata[CTRL_CPOL],
                 cpha:      reg_wdata[CTRL_CPHA],
                 rate:      reg_wdata[1:0]};
      end
      if (go) begin
        busy  <= 1'b1;
        sck_r <= reg_wdata[CTRL_CPOL];
      end else if (busy && cfg.master && m_ovf) begin
        sck_r <= !sck_r;
      end
      if (wr_ok && reg_addr == A_DATA)   data_r   <= reg_wdata;
      if (wr_ok && reg_addr == A_RELOAD) reload_r <= reg_wdata[CNT_W-1:0];
      if (reg_we && reg_addr == A_FLAGS) begin
        od_r <= reg_wdata[FLG_OD];
        if (reg_wdata[FLG_IRQ]) irq_r <= 1'b0;
      end
      if (done) begin
        busy   <= 1'b0;
        cfg.en <= 1'b0;
        data_r <= rx_byte;
        irq_r  <= 1'b1;
      end
    end
  end

  assign data_q = data_r;
  assign ctrl_q = {cfg.en, busy, cfg.master, cfg.lsb_first, cfg.cpol, cfg.cpha, cfg.rate};
  assign irq    = irq_r;
  assign od_en  = od_r;
  assign sck_o  = (busy && cfg.master) ? sck_r : cfg.cpol;
  assign sck_oe = cfg.master;

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(data_r));

  assert_self_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !cfg.en);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_r) |-> $past(done));

  assert_sck_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && cfg.master |-> sck_r == cfg.cpol);

endmodule

// File: tb/sim_sio_xcvr.sv
module sim_sio_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] data_q, ctrl_q;
  logic       irq, od_en, sck_o, sck_oe, so;
  logic       sck_i = 1'b0;
  logic       si = 1'b0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  sio_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .data_q(data_q), .ctrl_q(ctrl_q), .irq(irq),
    .od_en(od_en), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .si(si), .so(so)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] cw(input bit en, input bit go, input bit mst,
                                    input bit lsb, input bit cpol, input bit cpha,
                                    input logic [1:0] rate);
    return {en, go, mst, lsb, cpol, cpha, rate};
  endfunction

  task automatic wait_idle();
    for (int g = 0; g < 20000 && ctrl_q[6]; g++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 data_q", data_q, 0);
    check("R1 ctrl_q", ctrl_q, 0);
    check("R1 irq/od/sck/oe/so", {irq, od_en, sck_o, sck_oe, so}, 0);
  endtask

  task automatic t_master(input bit lsb, input bit cpol, input bit cpha,
                          input logic [7:0] tx, input logic [7:0] dev);
    logic [7:0] seen;
    int edges;
    int k;
    int idx;
    logic prev;
    seen = 8'h00; edges = 0;
    wr(A_DATA_C, tx);
    wr(2'd2, 8'hFE);
    wr(2'd0, cw(1, 0, 1, lsb, cpol, cpha, 2'd0));
    check("R6 idle level", sck_o, cpol);
    check("R6 oe master", sck_oe, 1);
    check("R3 enable only no start", ctrl_q[6], 0);
    si = dev[lsb ? 0 : 7];
    prev = sck_o;
    wr(2'd0, cw(1, 1, 1, lsb, cpol, cpha, 2'd0));
    check("R3 busy after start", ctrl_q[6], 1);
    for (int g = 0; g < 2000 && edges < 16; g++) begin
      @(negedge clk);
      if (sck_o !== prev) begin
        prev = sck_o;
        edges++;
        k = (edges - 1) / 2;
        idx = lsb ? k : 7 - k;
        if (edges % 2 == 1) begin
          if (!cpha) seen[idx] = so;
          else       si = dev[idx];
        end else begin
          if (cpha) seen[idx] = so;
          else if (k < 7) si = dev[lsb ? k + 1 : 6 - k];
        end
        if (edges == 8) check("R4 data held during transfer", data_q, tx);
      end
    end
    @(negedge clk);
    check("R5 R7 bits seen on so", seen, tx);
    check("R4 R5 captured byte", data_q, dev);
    check("R10 self disable", ctrl_q[7:6], 0);
    check("R9 irq set", irq, 1);
    check("R6 sck back at idle", sck_o, cpol);
    wr(2'd3, 8'h01);
  endtask

  localparam logic [1:0] A_DATA_C = 2'd1;

  task automatic t_slave(input bit lsb, input bit cpol, input bit cpha,
                         input logic [7:0] tx, input logic [7:0] dev);
    logic [7:0] seen;
    int idx;
    seen = 8'h00;
    sck_i = cpol;
    wr(2'd1, tx);
    wr(2'd0, cw(1, 0, 0, lsb, cpol, cpha, 2'd3));
    repeat (4) @(negedge clk);
    si = dev[lsb ? 0 : 7];
    wr(2'd0, cw(1, 1, 0, lsb, cpol, cpha, 2'd3));
    check("R12 oe off in slave", sck_oe, 0);
    for (int k = 0; k < 8; k++) begin
      idx = lsb ? k : 7 - k;
      repeat (8) @(negedge clk);
      if (!cpha) seen[idx] = so;
      sck_i = !cpol;
      if (cpha) si = dev[idx];
      repeat (8) @(negedge clk);
      if (cpha) seen[idx] = so;
      sck_i = cpol;
      if (!cpha && k < 7) si = dev[lsb ? k + 1 : 6 - k];
    end
    repeat (8) @(negedge clk);
    check("R12 R5 slave so bits", seen, tx);
    check("R12 R4 slave captured", data_q, dev);
    check("R12 R10 slave done", ctrl_q[7:6], 0);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_rate(input logic [1:0] rate, input logic [7:0] rl, input int exp_half);
    int n;
    logic prev;
    wr(2'd2, rl);
    wr(2'd0, cw(1, 0, 1, 0, 0, 0, rate));
    prev = sck_o;
    wr(2'd0, cw(1, 1, 1, 0, 0, 0, rate));
    for (int g = 0; g < 5000 && sck_o === prev; g++) @(negedge clk);
    prev = sck_o;
    n = 0;
    for (int g = 0; g < 5000 && sck_o === prev; g++) begin
      @(negedge clk);
      n++;
    end
    check("R8 half period", n, exp_half);
    wait_idle();
    wr(2'd3, 8'h01);
  endtask

  task automatic t_busy_ignore();
    si = 1'b1;
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hF0);
    wr(2'd0, cw(1, 0, 1, 0, 0, 0, 2'd1));
    wr(2'd0, cw(1, 1, 1, 0, 0, 0, 2'd1));
    repeat (20) @(negedge clk);
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    check("R11 data write ignored", data_q, 8'h3C);
    check("R11 ctrl write ignored", ctrl_q, cw(1, 1, 1, 0, 0, 0, 2'd1));
    wait_idle();
    @(negedge clk);
    check("R11 R4 result after ignored writes", data_q, 8'hFF);
    check("R9 irq after transfer", irq, 1);
  endtask

  task automatic t_flags();
    wr(2'd3, 8'h00);
    check("R9 irq kept by zero write", irq, 1);
    wr(2'd3, 8'h02);
    check("R13 od flag set", od_en, 1);
    check("R9 irq still set", irq, 1);
    wr(2'd3, 8'h01);
    check("R9 irq cleared", irq, 0);
    check("R13 od flag follows write", od_en, 0);
  endtask

  task automatic t_start_gate();
    wr(2'd0, cw(0, 1, 1, 1, 1, 0, 2'd2));
    check("R3 go without enable", ctrl_q, cw(0, 0, 1, 1, 1, 0, 2'd2));
    repeat (50) @(negedge clk);
    check("R3 no clock activity", sck_o, 1);
    check("R3 no irq", irq, 0);
    wr(2'd0, cw(1, 0, 0, 0, 0, 1, 2'd1));
    check("R2 R3 ctrl readback", ctrl_q, cw(1, 0, 0, 0, 0, 1, 2'd1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_start_gate();
    for (int m = 0; m < 8; m++)
      t_master(m[2], m[1], m[0], 8'hA1 ^ 8'(m * 29), 8'h6B ^ 8'(m * 17));
    t_slave(0, 0, 0, 8'hC5, 8'h39);
    t_slave(1, 1, 1, 8'h1E, 8'hD2);
    t_slave(0, 1, 0, 8'h87, 8'h4C);
    t_rate(2'd1, 8'hFC, 32);
    t_rate(2'd2, 8'hFF, 16);
    t_rate(2'd3, 8'hFE, 64);
    t_busy_ignore();
    t_flags();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule